// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the data-phase engine of an I2C master. Once the address phase is over, software signals that the bus is held and the block takes over. It keeps SCL low, waiting for a handshake. The handshake is a read of the primary status register followed by a write of the next byte. The block then shifts that byte out MSB-first over open-drain style pull-down enables and samples the acknowledge on the ninth pulse. After a good acknowledge it parks SCL low again until software repeats the handshake.

A STOP may be requested while a byte is in flight; it is produced once that byte has been acknowledged. The block then drops back to slave mode. The block watches the bus for START and STOP conditions and keeps a busy indication from them. It flags:

- misplaced conditions as bus errors,
- a missing acknowledge as an acknowledge failure,
- a lost arbitration, which also forces slave mode.

After any of these errors SCL is released. Software resumes after an acknowledge failure or a bus error by requesting either a repeated START or a STOP. SCL timing comes from a fixed divider of DIV clock cycles per half period, and the block waits for SCL to actually read high before it times the high phase.

Top module: `i2c_mtx`

## Requirements
- R1: After reset, both pull-down enables, all five flags, busy, the master-mode bit and the interrupt are 0.
- R2: SDA falling while SCL is high (START) sets busy; SDA rising while SCL is high (STOP) clears busy. The exception is the first two pulses of a byte frame, where either condition clears busy.
- R3: A pulse on addr_done_i sets the master-mode bit and drives SCL low. A byte starts only on a data write that follows a primary status read. A data write without that read leaves SCL low and sends nothing.
- R4: Each byte is sent MSB first, with SDA changed only while SCL is low. SDA low on the 9th pulse sets btf_o and evf_o and leaves SCL held low. irq_o equals ien_i AND evf_o.
- R5: A STOP request raised during a byte produces a STOP condition after that byte is acknowledged. Once the STOP is on the bus, the master-mode bit is 0 and busy is 0.
- R6: A START or STOP seen during pulses 3 to 9 of a frame sets berr_o and evf_o, releases SCL and leaves SDA as it was.
- R7: A START or STOP seen during pulse 1 or 2 does not set berr_o; it clears busy, and the byte completes normally.
- R8: SDA high on the 9th pulse sets af_o and evf_o and releases SCL. The block stays stopped until a request. A START request then produces a repeated START and returns to waiting with SCL low, in master mode. A STOP request produces a STOP and enters slave mode.
- R9: A secondary status read made while the high phase of the failing 9th pulse is still running leaves af_o set. A secondary status read made after that high phase clears af_o.
- R10: When the block releases SDA for a 1 bit and reads SDA low as SCL rises, it sets arl_o and evf_o. It also clears the master-mode bit and releases both SCL and SDA.
- R11: A secondary status read clears berr_o, af_o and arl_o. The next byte start clears btf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level read from the bus |
| sda_i | input | 1 | SDA level read from the bus |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_done_i | input | 1 | Address phase finished, take master data phase |
| sr1_rd_i | input | 1 | Primary status register read strobe |
| sr2_rd_i | input | 1 | Secondary status register read strobe |
| dr_wr_i | input | 1 | Data register write strobe |
| dr_wdata_i | input | DW | Data register write value |
| start_req_i | input | 1 | Request a repeated START after an error |
| stop_req_i | input | 1 | Request a STOP |
| ien_i | input | 1 | Interrupt enable |
| evf_o | output | 1 | Event flag, OR of the four event causes |
| btf_o | output | 1 | Byte transfer finished |
| berr_o | output | 1 | Bus error |
| af_o | output | 1 | Acknowledge failure |
| arl_o | output | 1 | Arbitration lost |
| busy_o | output | 1 | Bus busy |
| msl_o | output | 1 | Master mode |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench places a START and a STOP inside the first pulse of a byte, where a design that counts pulses wrongly would raise a bus error and abort. It also places a START in the third pulse, where a design that misses it would keep clocking. It reads the secondary status inside the failing ninth pulse: a design with clear-dominant flags would lose the acknowledge failure there. It pulls SDA low before the rising edge of a 1 bit: a design that samples arbitration late would see a START instead of arbitration loss. Random bytes with random interrupt enables are checked against a model of the slave, which catches bit-order errors, errors in the handshake that releases SCL, and errors in the interrupt masking.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LOW,
    ST_RISE,
    ST_HIGH,
    ST_HOLD,
    ST_C_LOW,
    ST_C_RISE,
    ST_C_HIGH,
    ST_C_TAIL
  } state_e;
endpackage

// File: rtl/i2c_mtx_cond_det.sv
module i2c_mtx_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_mtx_timer.sv
module i2c_mtx_timer #(
  parameter int DIV = 4,
  localparam int CW = $clog2(DIV + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CW'(DIV - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_mtx_flags.sv
module i2c_mtx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btf_set_i,
  input  logic btf_clr_i,
  input  logic berr_set_i,
  input  logic af_set_i,
  input  logic arl_set_i,
  input  logic sr2_rd_i,
  input  logic ien_i,
  output logic btf_o,
  output logic berr_o,
  output logic af_o,
  output logic arl_o,
  output logic evf_o,
  output logic irq_o
);
  logic btf_q, berr_q, af_q, arl_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      btf_q  <= 1'b0;
      berr_q <= 1'b0;
      af_q   <= 1'b0;
      arl_q  <= 1'b0;
    end else begin
      btf_q  <= btf_set_i | (btf_q & ~btf_clr_i);
      berr_q <= berr_set_i | (berr_q & ~sr2_rd_i);
      af_q   <= af_set_i | (af_q & ~sr2_rd_i);
      arl_q  <= arl_set_i | (arl_q & ~sr2_rd_i);
    end
  end

  assign btf_o  = btf_q;
  assign berr_o = berr_q;
  assign af_o   = af_q;
  assign arl_o  = arl_q;
  assign evf_o  = btf_q | berr_q | af_q | arl_q;
  assign irq_o  = ien_i & evf_o;

  a_r9_af_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (af_q && !sr2_rd_i) |=> af_q);
  a_r11_sr2_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr2_rd_i && !af_set_i && !berr_set_i && !arl_set_i) |=> (!af_q && !berr_q && !arl_q));
endmodule

// File: rtl/i2c_mtx_fsm.sv
module i2c_mtx_fsm
  import i2c_mtx_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          start_det_i,
  input  logic          stop_det_i,
  input  logic          tmr_done_i,
  input  logic          addr_done_i,
  input  logic          sr1_rd_i,
  input  logic          dr_wr_i,
  input  logic [DW-1:0] dr_wdata_i,
  input  logic          start_req_i,
  input  logic          stop_req_i,
  output logic          tmr_load_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          msl_o,
  output logic          busy_o,
  output logic          btf_set_o,
  output logic          btf_clr_o,
  output logic          berr_set_o,
  output logic          af_set_o,
  output logic          arl_set_o
);
  state_e        st_q, st_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          scl_oe_q, scl_oe_d, sda_oe_q, sda_oe_d;
  logic          msl_q, msl_d, busy_q, busy_d;
  logic          stop_pend_q, stop_pend_d, cond_q, cond_d, nack_q, nack_d;
  logic          sr1_seen_q;
  logic          in_frame, early, ack_pulse, any_cond;

  assign in_frame  = (st_q == ST_LOW) || (st_q == ST_RISE) || (st_q == ST_HIGH);
  assign early     = bit_q < BW'(2);
  assign ack_pulse = bit_q == BW'(DW);
  assign any_cond  = start_det_i | stop_det_i;

  always_comb begin
    st_d        = st_q;
    sh_d        = sh_q;
    bit_d       = bit_q;
    scl_oe_d    = scl_oe_q;
    sda_oe_d    = sda_oe_q;
    msl_d       = msl_q;
    cond_d      = cond_q;
    nack_d      = nack_q;
    stop_pend_d = stop_pend_q | (stop_req_i & msl_q);
    tmr_load_o  = 1'b0;
    btf_set_o   = 1'b0;
    btf_clr_o   = 1'b0;
    berr_set_o  = 1'b0;
    af_set_o    = 1'b0;
    arl_set_o   = 1'b0;

    if (in_frame && early && any_cond) busy_d = 1'b0;
    else if (start_det_i)              busy_d = 1'b1;
    else if (stop_det_i)               busy_d = 1'b0;
    else                               busy_d = busy_q;

    unique case (st_q)
      ST_IDLE: begin
        scl_oe_d = 1'b0;
        sda_oe_d = 1'b0;
        if (addr_done_i) begin
          msl_d       = 1'b1;
          scl_oe_d    = 1'b1;
          stop_pend_d = 1'b0;
          st_d        = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (dr_wr_i && sr1_seen_q) begin
          sh_d       = dr_wdata_i;
          bit_d      = '0;
          tmr_load_o = 1'b1;
          btf_clr_o  = 1'b1;
          st_d       = ST_LOW;
        end
      end
      ST_LOW: begin
        sda_oe_d = ack_pulse ? 1'b0 : ~sh_q[DW-1];
        if (tmr_done_i) begin
          scl_oe_d = 1'b0;
          st_d     = ST_RISE;
        end
      end
      ST_RISE: begin
        if (scl_i) begin
          tmr_load_o = 1'b1;
          st_d       = ST_HIGH;
          if (ack_pulse) begin
            nack_d   = sda_i;
            af_set_o = sda_i;
          end else if (sh_q[DW-1] && !sda_i) begin
            arl_set_o   = 1'b1;
            msl_d       = 1'b0;
            sda_oe_d    = 1'b0;
            stop_pend_d = 1'b0;
            st_d        = ST_IDLE;
          end
        end
      end
      ST_HIGH: begin
        if (ack_pulse && nack_q) af_set_o = 1'b1;
        if (tmr_done_i) begin
          if (!ack_pulse) begin
            scl_oe_d   = 1'b1;
            sh_d       = sh_q << 1;
            bit_d      = bit_q + 1'b1;
            tmr_load_o = 1'b1;
            st_d       = ST_LOW;
          end else if (nack_q) begin
            st_d = ST_HOLD;
          end else begin
            btf_set_o = 1'b1;
            scl_oe_d  = 1'b1;
            if (stop_pend_q) begin
              cond_d      = 1'b0;
              stop_pend_d = 1'b0;
              tmr_load_o  = 1'b1;
              st_d        = ST_C_LOW;
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
      end
      ST_HOLD: begin
        scl_oe_d    = 1'b0;
        stop_pend_d = 1'b0;
        if (start_req_i || stop_req_i) begin
          cond_d     = start_req_i;
          scl_oe_d   = 1'b1;
          tmr_load_o = 1'b1;
          st_d       = ST_C_LOW;
        end
      end
      ST_C_LOW: begin
        sda_oe_d = ~cond_q;
        if (tmr_done_i) begin
          scl_oe_d = 1'b0;
          st_d     = ST_C_RISE;
        end
      end
      ST_C_RISE: begin
        if (scl_i) begin
          tmr_load_o = 1'b1;
          st_d       = ST_C_HIGH;
        end
      end
      ST_C_HIGH: begin
        if (tmr_done_i) begin
          sda_oe_d   = cond_q;
          tmr_load_o = 1'b1;
          st_d       = ST_C_TAIL;
        end
      end
      ST_C_TAIL: begin
        if (tmr_done_i) begin
          if (cond_q) begin
            scl_oe_d = 1'b1;
            st_d     = ST_WAIT;
          end else begin
            msl_d = 1'b0;
            st_d  = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase

    // misplaced condition inside pulses 3..9 aborts the frame
    if (in_frame && !early && any_cond) begin
      berr_set_o = 1'b1;
      btf_set_o  = 1'b0;
      scl_oe_d   = 1'b0;
      sda_oe_d   = sda_oe_q;
      tmr_load_o = 1'b0;
      st_d       = ST_HOLD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      sh_q        <= '0;
      bit_q       <= '0;
      scl_oe_q    <= 1'b0;
      sda_oe_q    <= 1'b0;
      msl_q       <= 1'b0;
      busy_q      <= 1'b0;
      stop_pend_q <= 1'b0;
      cond_q      <= 1'b0;
      nack_q      <= 1'b0;
      sr1_seen_q  <= 1'b0;
    end else begin
      st_q        <= st_d;
      sh_q        <= sh_d;
      bit_q       <= bit_d;
      scl_oe_q    <= scl_oe_d;
      sda_oe_q    <= sda_oe_d;
      msl_q       <= msl_d;
      busy_q      <= busy_d;
      stop_pend_q <= stop_pend_d;
      cond_q      <= cond_d;
      nack_q      <= nack_d;
      if (dr_wr_i)       sr1_seen_q <= 1'b0;
      else if (sr1_rd_i) sr1_seen_q <= 1'b1;
    end
  end

  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;
  assign msl_o    = msl_q;
  assign busy_o   = busy_q;

  a_r4_sda_quiet_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HIGH && $past(st_q) == ST_HIGH) |-> $stable(sda_oe_q));
  a_r10_arl_to_slave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arl_set_o |=> (!msl_q && !scl_oe_q && !sda_oe_q));
  a_r3_wait_for_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !dr_wr_i) |=> (st_q == ST_WAIT && scl_oe_q));
endmodule

// File: rtl/i2c_mtx.sv
module i2c_mtx #(
  parameter int DW  = 8,
  parameter int DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  input  logic          addr_done_i,
  input  logic          sr1_rd_i,
  input  logic          sr2_rd_i,
  input  logic          dr_wr_i,
  input  logic [DW-1:0] dr_wdata_i,
  input  logic          start_req_i,
  input  logic          stop_req_i,
  input  logic          ien_i,
  output logic          evf_o,
  output logic          btf_o,
  output logic          berr_o,
  output logic          af_o,
  output logic          arl_o,
  output logic          busy_o,
  output logic          msl_o,
  output logic          irq_o
);
  logic start_det, stop_det, tmr_load, tmr_done;
  logic btf_set, btf_clr, berr_set, af_set, arl_set;

  initial begin
    assert (DIV >= 2) else $error("DIV must be at least 2");
  end

  i2c_mtx_cond_det u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (start_det),
    .stop_o  (stop_det)
  );

  i2c_mtx_timer #(.DIV(DIV)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .done_o (tmr_done)
  );

  i2c_mtx_fsm #(.DW(DW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .start_det_i (start_det),
    .stop_det_i  (stop_det),
    .tmr_done_i  (tmr_done),
    .addr_done_i (addr_done_i),
    .sr1_rd_i    (sr1_rd_i),
    .dr_wr_i     (dr_wr_i),
    .dr_wdata_i  (dr_wdata_i),
    .start_req_i (start_req_i),
    .stop_req_i  (stop_req_i),
    .tmr_load_o  (tmr_load),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o),
    .msl_o       (msl_o),
    .busy_o      (busy_o),
    .btf_set_o   (btf_set),
    .btf_clr_o   (btf_clr),
    .berr_set_o  (berr_set),
    .af_set_o    (af_set),
    .arl_set_o   (arl_set)
  );

  i2c_mtx_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .btf_set_i  (btf_set),
    .btf_clr_i  (btf_clr),
    .berr_set_i (berr_set),
    .af_set_i   (af_set),
    .arl_set_i  (arl_set),
    .sr2_rd_i   (sr2_rd_i),
    .ien_i      (ien_i),
    .btf_o      (btf_o),
    .berr_o     (berr_o),
    .af_o       (af_o),
    .arl_o      (arl_o),
    .evf_o      (evf_o),
    .irq_o      (irq_o)
  );

  a_r6_berr_frees_scl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(berr_o) |-> !scl_oe_o);
  a_r4_btf_holds_scl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(btf_o) |-> scl_oe_o);
  a_r8_af_frees_scl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(af_o) |=> !scl_oe_o);
endmodule

// File: tb/tb_i2c_mtx.sv
module tb_i2c_mtx;
  localparam int DW  = 8;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_oe, sda_oe;
  logic ext_scl_lo = 1'b0, ext_sda_lo = 1'b0, slv_lo;
  logic scl_bus, sda_bus;
  logic addr_done = 0, sr1_rd = 0, sr2_rd = 0, dr_wr = 0, start_req = 0, stop_req = 0, ien = 0;
  logic [DW-1:0] dr_data = '0;
  logic evf, btf, berr, af, arl, busy, msl, irq;

  assign scl_bus = ~(scl_oe | ext_scl_lo);
  assign sda_bus = ~(sda_oe | ext_sda_lo | slv_lo);

  i2c_mtx #(.DW(DW), .DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .addr_done_i(addr_done),
    .sr1_rd_i(sr1_rd), .sr2_rd_i(sr2_rd), .dr_wr_i(dr_wr), .dr_wdata_i(dr_data),
    .start_req_i(start_req), .stop_req_i(stop_req), .ien_i(ien),
    .evf_o(evf), .btf_o(btf), .berr_o(berr), .af_o(af), .arl_o(arl),
    .busy_o(busy), .msl_o(msl), .irq_o(irq)
  );

  // bus slave and condition monitor
  logic slv_clr = 1'b0, ack_en = 1'b1;
  logic scl_prev = 1'b1, sda_prev = 1'b1;
  logic [7:0] rx = '0, got = '0;
  int rcnt = 0, nbytes = 0, starts = 0, stops = 0;
  initial slv_lo = 1'b0;

  always @(negedge clk) begin
    if (slv_clr) begin
      rcnt   <= 0;
      slv_lo <= 1'b0;
    end else begin
      if (scl_bus && !scl_prev) begin
        if (rcnt < 8) rx <= {rx[6:0], sda_bus};
        rcnt <= rcnt + 1;
      end
      if (!scl_bus && scl_prev) begin
        if (rcnt == 8) slv_lo <= ack_en;
        else if (rcnt == 9) begin
          slv_lo <= 1'b0;
          rcnt   <= 0;
          got    <= rx;
          nbytes <= nbytes + 1;
        end
      end
    end
    if (scl_bus && scl_prev && sda_prev && !sda_bus) starts <= starts + 1;
    if (scl_bus && scl_prev && !sda_prev && sda_bus) stops <= stops + 1;
    scl_prev <= scl_bus;
    sda_prev <= sda_bus;
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  function automatic logic exp_irq(input logic en, input logic ev);
    return en & ev;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_slave();
    slv_clr = 1'b1; cyc(1); slv_clr = 1'b0;
  endtask

  task automatic enter_master();
    ext_sda_lo = 1'b1; cyc(3);
    ext_scl_lo = 1'b1; cyc(2);
    ext_sda_lo = 1'b0;
    addr_done = 1'b1; cyc(1); addr_done = 1'b0; cyc(2);
    ext_scl_lo = 1'b0;
    clr_slave();
  endtask

  task automatic handshake(input logic [7:0] b);
    sr1_rd = 1'b1; cyc(1); sr1_rd = 1'b0;
    dr_wr = 1'b1; dr_data = b; cyc(1); dr_wr = 1'b0;
  endtask

  task automatic wait_evf();
    for (int i = 0; i < 400 && !evf; i++) cyc(1);
  endtask

  task automatic pulse_sr2();
    sr2_rd = 1'b1; cyc(1); sr2_rd = 1'b0;
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 100 && scl_bus; i++) cyc(1);
    for (int i = 0; i < 100 && !scl_bus; i++) cyc(1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    int n0, s0;
    b = 8'($urandom(32'h5EED_1234));
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 reset outputs", {scl_oe, sda_oe, evf, btf, berr, af, arl, busy, msl, irq}, '0);

    enter_master();
    chk("R2 START sets busy", busy, 1);
    chk("R3 master bit", msl, 1);
    chk("R3 SCL held after address", scl_oe, 1);

    n0 = nbytes;
    dr_wr = 1'b1; dr_data = 8'h3C; cyc(1); dr_wr = 1'b0; cyc(40);
    chk("R3 write without status read keeps SCL low", scl_oe, 1);
    chk("R3 write without status read sends nothing", nbytes, n0);

    // random bytes, random interrupt enable
    for (int k = 0; k < 8; k++) begin
      b = 8'($urandom);
      ien = 1'($urandom);
      handshake(b);
      if (k == 1) chk("R11 byte start clears btf", btf, 0);
      wait_evf(); cyc(2);
      chk("R4 byte MSB first", got, b);
      chk("R4 btf on ACK", btf, 1);
      chk("R4 irq masking", irq, exp_irq(ien, evf));
      chk("R4 SCL held after ACK", scl_oe, 1);
    end

    // NACK, flag re-assert inside the 9th pulse, then repeated START
    ien = 1'b1; ack_en = 1'b0;
    handshake(8'h96);
    for (int i = 0; i < 400 && !af; i++) cyc(1);
    sr2_rd = 1'b1; cyc(1); sr2_rd = 1'b0;
    chk("R9 early status read does not clear af", af, 1);
    cyc(10);
    chk("R8 af and evf", {af, evf, irq}, 3'b111);
    chk("R8 SCL released after NACK", scl_oe, 0);
    pulse_sr2();
    chk("R9 late status read clears af", af, 0);
    ack_en = 1'b1;
    s0 = starts;
    start_req = 1'b1; cyc(1); start_req = 1'b0;
    cyc(40);
    chk("R8 repeated START on bus", starts, s0 + 1);
    chk("R8 back to waiting with SCL low", {scl_oe, msl, busy}, 3'b111);
    clr_slave();
    handshake(8'h5A);
    wait_evf(); cyc(2);
    chk("R8 transfer resumes", got, 8'h5A);

    // STOP after last byte
    s0 = stops;
    handshake(8'hC3);
    stop_req = 1'b1; cyc(1); stop_req = 1'b0;
    for (int i = 0; i < 400 && msl; i++) cyc(1);
    cyc(2);
    chk("R5 STOP on bus", stops, s0 + 1);
    chk("R5 slave mode, bus free", {msl, busy, scl_oe, sda_oe}, 4'b0000);
    chk("R5 last byte delivered", got, 8'hC3);
    clr_slave();

    // arbitration lost on first bit
    enter_master();
    handshake(8'hA5);
    ext_sda_lo = 1'b1;
    for (int i = 0; i < 100 && !arl; i++) cyc(1);
    cyc(1);
    chk("R10 arbitration lost", {arl, evf, irq}, 3'b111);
    chk("R10 slave mode, lines released", {msl, scl_oe, sda_oe}, 3'b000);
    ext_sda_lo = 1'b0; cyc(2);
    chk("R2 STOP clears busy", busy, 0);
    pulse_sr2();
    chk("R11 status read clears arl", arl, 0);
    clr_slave();

    // misplaced START/STOP in pulse 1
    enter_master();
    handshake(8'hFF);
    wait_rise();
    cyc(2); ext_sda_lo = 1'b1; cyc(1); ext_sda_lo = 1'b0;
    cyc(2);
    chk("R7 busy cleared by early condition", busy, 0);
    wait_evf(); cyc(2);
    chk("R7 no bus error in pulse 1", berr, 0);
    chk("R7 byte completes", {btf, 8'(got)}, {1'b1, 8'hFF});

    // bus error in pulse 3
    handshake(8'hFF);
    for (int i = 0; i < 200 && rcnt != 2; i++) cyc(1);
    wait_rise();
    cyc(2); ext_sda_lo = 1'b1; cyc(2);
    chk("R6 bus error flagged", {berr, evf}, 2'b11);
    chk("R6 SCL released", scl_oe, 0);
    chk("R6 SDA left as driven", sda_oe, 0);
    chk("R2 START sets busy mid-frame", busy, 1);
    ext_sda_lo = 1'b0; cyc(2);
    chk("R2 STOP clears busy", busy, 0);
    pulse_sr2();
    chk("R11 status read clears berr", berr, 0);
    stop_req = 1'b1; cyc(1); stop_req = 1'b0;
    cyc(40);
    chk("R8 STOP request leaves master mode", msl, 0);

    finish_run();
  end
endmodule